// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block runs the handshake for one 8-bit peripheral port that moves data under strobe control. Data can move in one direction, or both ways on the same pins. When the port receives, the peripheral pulls its strobe low, and the block captures the pin data. It then raises a buffer-full flag. When the strobe returns high, it can interrupt the host. The flag and the interrupt clear when the host reads the byte. When the port sends, a host write loads the output holding register. The block then pulls an active-low buffer-full line low to tell the peripheral that a byte is waiting. The peripheral's active-low acknowledge sends that line high again. When the acknowledge ends, the block can interrupt the host to ask for the next byte.

A two-bit mode input selects receive-only, send-only or two-way operation. In two-way operation the pins are driven only while the acknowledge is held low, and the rest of the time they are left floating. Each direction has its own interrupt-enable bit. Firmware sets or clears these bits one at a time with single-bit writes. All strobe and acknowledge lines are taken as already synchronous to the clock. Every edge on them is detected against the value sampled on the previous clock.

Top module: `hs_port_ctrl`

## Requirements
- R1: On a falling edge of `stb_n` while receive is enabled, `pin_in` is captured. The captured byte appears on `host_rdata` one clock later, and `host_rdata` holds that value until the next capture.
- R2: A captured strobe falling edge sets `ibf` to 1 on the next clock. `ibf` stays 1 until it is cleared as R3 describes.
- R3: A `host_rd` pulse clears `ibf` on the next clock. If a strobe falling edge lands in the same cycle, the strobe wins: `ibf` stays 1 and the new byte is captured.
- R4: The receive interrupt sets on a rising edge of `stb_n` when `ibf` is 1, the receive enable is 1, and there is no `host_rd` in that cycle. A `host_rd` clears the receive interrupt on the next clock.
- R5: A `host_wr` while send is enabled does three things on the next clock: it loads `host_wdata` onto `pin_out`, drives `obf_n` to 0, and clears the send interrupt.
- R6: A falling edge of `ack_n` sets `obf_n` back to 1 on the next clock, unless a `host_wr` arrives in the same cycle.
- R7: A rising edge of `ack_n` sets the send interrupt when the send enable is 1. A `host_wr` in the same cycle wins, and the interrupt stays 0.
- R8: `pin_oe` follows the mode without delay. It is 1 in send-only mode, equal to the inverse of `ack_n` in two-way mode, and 0 in receive-only mode.
- R9: The `mode` encoding is 2'b00 receive-only, 2'b01 send-only, and 2'b10 or 2'b11 two-way. In a disabled direction the flags idle: `ibf`=0 with its interrupt 0, or `obf_n`=1 with its interrupt 0. Strobes, reads and writes aimed at that direction are ignored, and its data register keeps its value.
- R10: A `bsr_we` pulse writes `bsr_val` into the receive enable (`bsr_sel`=0) or into the send enable (`bsr_sel`=1). The new value takes effect from the next cycle. Clearing an enable does not withdraw an interrupt that is already pending.
- R11: Reset gives `ibf`=0, `obf_n`=1, `intr`=0, `host_rdata`=0, `pin_out`=0, and both enables 0.
- R12: `intr` is the OR of the receive and send interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Direction select (see R9) |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| pin_in | input | 8 | Port pins as seen by the block |
| pin_out | output | 8 | Output holding register to the pins |
| pin_oe | output | 1 | Pin driver enable |
| host_rd | input | 1 | One-cycle host read of the captured byte |
| host_wr | input | 1 | One-cycle host write of a byte to send |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Captured byte |
| bsr_we | input | 1 | Single-bit write to an interrupt enable |
| bsr_sel | input | 1 | Enable select: 0 receive, 1 send |
| bsr_val | input | 1 | Value written to the selected enable |
| ibf | output | 1 | Receive buffer full |
| obf_n | output | 1 | Send buffer full, active low |
| intr | output | 1 | Host interrupt request |

## Verification
Two pairs of events can land in the same clock. A peripheral strobe edge can coincide with a host read, and an acknowledge edge can coincide with a host write. In both cases one event sets a flag and the other clears it. Random stimulus toggles the strobe, the acknowledge, reads and writes independently on every cycle, so these collisions happen often. Directed cases also place a strobe falling edge on a read cycle and an acknowledge rising edge on a write cycle. The results are judged against a bench model in which the peripheral edge wins on the input side and the host write wins on the output side.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int HS_DW = 8;

  typedef enum logic [1:0] {
    HS_RX   = 2'b00,
    HS_TX   = 2'b01,
    HS_BI   = 2'b10,
    HS_BI_X = 2'b11
  } hs_mode_e;

  // receive side active in every mode except send-only
  function automatic logic rx_on(input logic [1:0] m);
    return m != HS_TX;
  endfunction

  // send side active in every mode except receive-only
  function automatic logic tx_on(input logic [1:0] m);
    return m != HS_RX;
  endfunction

  // pin drive: always in send-only, only under acknowledge in two-way
  function automatic logic drive_on(input logic [1:0] m, input logic ack_low);
    logic r;
    case (m)
      HS_RX:   r = 1'b0;
      HS_TX:   r = 1'b1;
      default: r = ack_low;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/hs_edge.sv
module hs_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= lvl[i];
    end
    assign fall[i] = prev_q[i] & ~lvl[i];
    assign rise[i] = ~prev_q[i] & lvl[i];
  end
endmodule

// File: rtl/hs_in_path.sv
module hs_in_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         stb_fall,
  input  logic         stb_rise,
  input  logic         rd,
  input  logic         ie,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         irq
);
  logic cap;
  assign cap = en & stb_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      full  <= 1'b0;
      irq   <= 1'b0;
    end else if (!en) begin
      full <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (cap) begin
        rdata <= pin_in;
        full  <= 1'b1;
      end else if (rd) begin
        full <= 1'b0;
      end
      if (rd)                         irq <= 1'b0;
      else if (stb_rise && full && ie) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/hs_out_path.sv
module hs_out_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         ack_fall,
  input  logic         ack_rise,
  input  logic         ie,
  output logic [W-1:0] odata,
  output logic         full_n,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odata  <= '0;
      full_n <= 1'b1;
      irq    <= 1'b0;
    end else if (!en) begin
      full_n <= 1'b1;
      irq    <= 1'b0;
    end else if (wr) begin
      odata  <= wdata;
      full_n <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (ack_fall)       full_n <= 1'b1;
      if (ack_rise && ie) irq    <= 1'b1;
    end
  end
endmodule

// File: rtl/hs_port_ctrl.sv
module hs_port_ctrl #(
  parameter int W = hs_pkg::HS_DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         stb_n,
  input  logic         ack_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic         pin_oe,
  input  logic         host_rd,
  input  logic         host_wr,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] host_rdata,
  input  logic         bsr_we,
  input  logic         bsr_sel,
  input  logic         bsr_val,
  output logic         ibf,
  output logic         obf_n,
  output logic         intr
);
  import hs_pkg::*;

  localparam int NLINE = 2;
  localparam int L_STB = 0;
  localparam int L_ACK = 1;

  logic [NLINE-1:0] fall_ev, rise_ev;
  logic stb_fall, stb_rise, ack_fall, ack_rise;
  logic rx_en, tx_en;
  logic [1:0] ie_q;
  logic rx_irq, tx_irq;

  hs_edge #(.N(NLINE)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({ack_n, stb_n}),
    .fall (fall_ev),
    .rise (rise_ev)
  );

  assign stb_fall = fall_ev[L_STB];
  assign stb_rise = rise_ev[L_STB];
  assign ack_fall = fall_ev[L_ACK];
  assign ack_rise = rise_ev[L_ACK];

  assign rx_en = rx_on(mode);
  assign tx_en = tx_on(mode);

  // interrupt enables, one bit each, written singly
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ie_q <= '0;
    else if (bsr_we) ie_q[bsr_sel] <= bsr_val;
  end

  hs_in_path #(.W(W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (rx_en),
    .stb_fall(stb_fall),
    .stb_rise(stb_rise),
    .rd      (host_rd),
    .ie      (ie_q[0]),
    .pin_in  (pin_in),
    .rdata   (host_rdata),
    .full    (ibf),
    .irq     (rx_irq)
  );

  hs_out_path #(.W(W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (tx_en),
    .wr      (host_wr),
    .wdata   (host_wdata),
    .ack_fall(ack_fall),
    .ack_rise(ack_rise),
    .ie      (ie_q[1]),
    .odata   (pin_out),
    .full_n  (obf_n),
    .irq     (tx_irq)
  );

  assign pin_oe = drive_on(mode, ~ack_n);
  assign intr   = rx_irq | tx_irq;
endmodule

// File: rtl/hs_port_chk.sv
module hs_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         host_rd,
  input logic         host_wr,
  input logic [W-1:0] host_wdata,
  input logic [W-1:0] pin_out,
  input logic         ibf,
  input logic         obf_n,
  input logic         intr,
  input logic         rx_en,
  input logic         tx_en,
  input logic         stb_fall,
  input logic         ack_fall,
  input logic         ack_rise,
  input logic [1:0]   ie_q
);
  // R2
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && stb_fall) |=> ibf);
  // R3
  ibf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && host_rd && !stb_fall) |=> !ibf);
  // R4
  rx_irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && host_rd) |=> !intr);
  // R5
  obf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && host_wr) |=> (!obf_n && pin_out == $past(host_wdata)));
  // R6
  obf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && ack_fall && !host_wr) |=> obf_n);
  // R7
  tx_irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && ack_rise && !host_wr && ie_q[1]) |=> intr);
  // R9
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> !ibf);
  // R9
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> obf_n);
endmodule

bind hs_port_ctrl hs_port_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .host_rd   (host_rd),
  .host_wr   (host_wr),
  .host_wdata(host_wdata),
  .pin_out   (pin_out),
  .ibf       (ibf),
  .obf_n     (obf_n),
  .intr      (intr),
  .rx_en     (rx_en),
  .tx_en     (tx_en),
  .stb_fall  (stb_fall),
  .ack_fall  (ack_fall),
  .ack_rise  (ack_rise),
  .ie_q      (ie_q)
);

// File: tb/tb_hs_port_ctrl.sv
module tb_hs_port_ctrl;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic stb_n = 1'b1, ack_n = 1'b1;
  logic [W-1:0] pin_in = '0, host_wdata = '0;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic bsr_we = 1'b0, bsr_sel = 1'b0, bsr_val = 1'b0;
  logic [W-1:0] pin_out, host_rdata;
  logic pin_oe, ibf, obf_n, intr;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model state
  bit m_stb = 1, m_ack = 1, m_ibf = 0, m_iirq = 0, m_obfn = 1, m_oirq = 0;
  bit [1:0] m_ie = 0;
  logic [W-1:0] m_rdata = '0, m_pout = '0;

  always #2 clk = ~clk;

  hs_port_ctrl #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .stb_n(stb_n), .ack_n(ack_n),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .bsr_we(bsr_we), .bsr_sel(bsr_sel),
    .bsr_val(bsr_val), .ibf(ibf), .obf_n(obf_n), .intr(intr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_oe(input logic [1:0] m, input bit ackn);
    if (m == 2'b00) return 1'b0;
    if (m == 2'b01) return 1'b1;
    return !ackn;
  endfunction

  task automatic model_update();
    bit rxa, txa, sf, sr, af, ar;
    bit n_ibf, n_iirq, n_obfn, n_oirq;
    rxa = (mode != 2'b01);
    txa = (mode != 2'b00);
    sf = m_stb && !stb_n;  sr = !m_stb && stb_n;
    af = m_ack && !ack_n;  ar = !m_ack && ack_n;
    n_ibf = m_ibf; n_iirq = m_iirq; n_obfn = m_obfn; n_oirq = m_oirq;
    if (!rxa) begin n_ibf = 0; n_iirq = 0; end
    else begin
      if (sf) begin m_rdata = pin_in; n_ibf = 1; end
      else if (host_rd) n_ibf = 0;
      if (host_rd) n_iirq = 0;
      else if (sr && m_ibf && m_ie[0]) n_iirq = 1;
    end
    if (!txa) begin n_obfn = 1; n_oirq = 0; end
    else if (host_wr) begin m_pout = host_wdata; n_obfn = 0; n_oirq = 0; end
    else begin
      if (af) n_obfn = 1;
      if (ar && m_ie[1]) n_oirq = 1;
    end
    if (bsr_we) m_ie[bsr_sel] = bsr_val;
    m_ibf = n_ibf; m_iirq = n_iirq; m_obfn = n_obfn; m_oirq = n_oirq;
    m_stb = stb_n; m_ack = ack_n;
  endtask

  // inputs were just driven at a falling edge; advance one clock and compare
  task automatic step();
    #1;
    check("R8 pin_oe", pin_oe, exp_oe(mode, ack_n));
    model_update();
    @(negedge clk);
    check("R1 host_rdata", host_rdata, m_rdata);
    check("R2/R3 ibf", ibf, m_ibf);
    check("R5/R6 obf_n", obf_n, m_obfn);
    check("R5 pin_out", pin_out, m_pout);
    check("R4/R7/R12 intr", intr, m_iirq | m_oirq);
  endtask

  task automatic quiet();
    host_rd = 0; host_wr = 0; bsr_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 ibf", ibf, 0);
    check("R11 obf_n", obf_n, 1);
    check("R11 intr", intr, 0);
    check("R11 host_rdata", host_rdata, 0);
    check("R11 pin_out", pin_out, 0);

    // R10: enables are 0 after reset, so a full receive cycle raises no interrupt
    stb_n = 0; pin_in = 8'h3C; step();
    stb_n = 1; step();
    check("R10 no irq while disabled", intr, 0);
    check("R1 captured", host_rdata, 8'h3C);
    host_rd = 1; step(); quiet();

    // R10/R4 enable receive interrupt, then strobe
    bsr_we = 1; bsr_sel = 0; bsr_val = 1; step(); quiet();
    stb_n = 0; pin_in = 8'hA5; step();
    check("R2 ibf after strobe", ibf, 1);
    stb_n = 1; step();
    check("R4 irq on strobe end", intr, 1);
    // R3: strobe fall collides with read: strobe wins
    stb_n = 0; pin_in = 8'h5A; host_rd = 1; step(); quiet();
    check("R3 strobe beats read", ibf, 1);
    check("R3 new byte", host_rdata, 8'h5A);
    check("R4 read drops irq", intr, 0);
    stb_n = 1; host_rd = 1; step(); quiet();
    check("R4 read on strobe end: no irq", intr, 0);

    // R9: host write ignored in receive-only mode
    host_wr = 1; host_wdata = 8'hEE; step(); quiet();
    check("R9 write ignored obf_n", obf_n, 1);
    check("R9 write ignored pin_out", pin_out, 0);

    // send path
    mode = 2'b01;
    bsr_we = 1; bsr_sel = 1; bsr_val = 1; step(); quiet();
    host_wr = 1; host_wdata = 8'hC4; step(); quiet();
    check("R5 obf_n low", obf_n, 0);
    check("R5 pin_out", pin_out, 8'hC4);
    ack_n = 0; step();
    check("R6 ack releases obf", obf_n, 1);
    // R7: ack end collides with host write: write wins
    ack_n = 1; host_wr = 1; host_wdata = 8'h11; step(); quiet();
    check("R7 write beats ack end", intr, 0);
    check("R7 obf_n still low", obf_n, 0);
    ack_n = 0; step();
    ack_n = 1; step();
    check("R7 irq on ack end", intr, 1);
    // R9: strobes ignored in send-only mode
    stb_n = 0; pin_in = 8'h77; step(); stb_n = 1; step();
    check("R9 strobe ignored", host_rdata, 8'h5A);

    // R8 two-way drive
    mode = 2'b10; ack_n = 0; #1 check("R8 bidir ack low", pin_oe, 1);
    step(); ack_n = 1; step();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if (i % 250 == 0) mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) < 3) stb_n = ~stb_n;
      if ($urandom_range(0, 9) < 3) ack_n = ~ack_n;
      pin_in = W'($urandom);
      host_wdata = W'($urandom);
      host_rd = ($urandom_range(0, 6) == 0);
      host_wr = ($urandom_range(0, 6) == 0);
      bsr_we = ($urandom_range(0, 19) == 0);
      bsr_sel = 1'($urandom);
      bsr_val = ($urandom_range(0, 3) != 0);
      step();
    end
    quiet();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule